// File: doc/BRIEF.md
# Adder-Subtractor with Flag-Based Compare

This block is a combinational two's-complement adder/subtractor of parameterised width (32 bits by default). It returns the sum or difference of two operands together with three condition flags: zero, overflow and negative. A small compare stage then turns those flags into a full-width Boolean word.

The compare stage reads the flags of the same adder. It has no separate magnitude comparator. When the subtract select is 1, the three compare codes give signed equal, signed less-than and signed less-or-equal of A against B. The result is 0 or 1 in bit 0, and every higher bit is 0.

Subtraction inverts B bit by bit and feeds a carry of 1 into the low bit of a ripple-carry chain. No carry-out leaves the block, and the block makes no unsigned comparisons.

Top module: `addsub_cmp`

## Requirements
- R1: With `sub_i` = 0, `sum_o` equals `a_i + b_i` modulo 2^W.
- R2: With `sub_i` = 1, `sum_o` equals `a_i - b_i` modulo 2^W. The block forms this by inverting B and forcing the carry-in to 1.
- R3: `zero_o` is 1 exactly when every bit of `sum_o` is 0.
- R4: `neg_o` equals the most significant bit of `sum_o`.
- R5: `ovf_o` is 1 exactly when the signed result of the selected operation falls outside the W-bit signed range. It is always 0 when A's sign differs from the sign of the operand actually added (B for add, inverted B for subtract).
- R6: `cmp_o[W-1:1]` is always 0.
- R7: With `cmp_sel_i` = 2'b01, `cmp_o[0]` equals `zero_o`. With the subtract select at 1, this means signed A == B.
- R8: With `cmp_sel_i` = 2'b10, `cmp_o[0]` equals `neg_o XOR ovf_o`. With the subtract select at 1, this means signed A < B.
- R9: With `cmp_sel_i` = 2'b11, `cmp_o[0]` equals `zero_o OR (neg_o XOR ovf_o)`. With the subtract select at 1, this means signed A <= B.
- R10: With `cmp_sel_i` = 2'b00, `cmp_o` is all zeros.
- R11: When the subtract select is 1, the flags never show zero together with negative, and never show zero together with overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| cmp_sel_i | input | 2 | Compare select: 00 none, 01 equal, 10 less-than, 11 less-or-equal |
| sum_o | output | W | Sum or difference |
| zero_o | output | 1 | Result is zero |
| ovf_o | output | 1 | Signed overflow |
| neg_o | output | 1 | Result sign bit |
| cmp_o | output | W | Compare result, 0 or 1 |

## Verification
The operands include alternating-bit words (0x55555555, 0xAAAAAAAA), all-ones and one-hot values. Used in adds, these put every combination of operand bits and carry-in on even and odd bit positions of the ripple chain, so a wrong sum or carry term in any stage shows up.

A fixed set of subtractions produces each reachable flag combination:
- equal operands give zero;
- a positive minus a negative that wraps gives overflow with a negative result;
- the most negative value minus one gives overflow with a non-negative result;
- plain cases give negative alone and no flags at all.

Each subtraction is run under all four compare selects, so the bench can tell whether a wrong answer comes from the flag logic or from the compare decode. A pseudo-random stream of mixed adds and subtracts then checks the flags against arithmetic done on wider signed integers.

// File: rtl/addsub_cmp.sv
`timescale 1ns/1ps
module addsub_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic [1:0]   cmp_sel_i,
  output logic [W-1:0] sum_o,
  output logic         zero_o,
  output logic         ovf_o,
  output logic         neg_o,
  output logic [W-1:0] cmp_o
);
  localparam int MSB = W - 1;
  localparam logic [1:0] SEL_NONE = 2'b00;
  localparam logic [1:0] SEL_EQ   = 2'b01;
  localparam logic [1:0] SEL_LT   = 2'b10;
  localparam logic [1:0] SEL_LE   = 2'b11;

  logic [W-1:0] xb;
  logic [W-1:0] cin;
  logic         lt;
  logic         bit0;

  assign xb     = b_i ^ {W{sub_i}};
  assign cin[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_rca
    assign sum_o[i] = a_i[i] ^ xb[i] ^ cin[i];
    if (i < MSB) begin : g_carry
      assign cin[i+1] = (a_i[i] & xb[i]) | (cin[i] & (a_i[i] ^ xb[i]));
    end
  end

  assign zero_o = ~|sum_o;
  assign neg_o  = sum_o[MSB];
  assign ovf_o  = (a_i[MSB] ~^ xb[MSB]) & (sum_o[MSB] ^ a_i[MSB]);
  assign lt     = neg_o ^ ovf_o;

  always_comb begin
    unique case (cmp_sel_i)
      SEL_NONE: bit0 = 1'b0;
      SEL_EQ:   bit0 = zero_o;
      SEL_LT:   bit0 = lt;
      SEL_LE:   bit0 = zero_o | lt;
      default:  bit0 = 1'b0;
    endcase
  end

  assign cmp_o = {{(W-1){1'b0}}, bit0};
endmodule

// File: rtl/addsub_cmp_chk.sv
`timescale 1ns/1ps
module addsub_cmp_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         sub_i,
  input logic [1:0]   cmp_sel_i,
  input logic [W-1:0] sum_o,
  input logic         zero_o,
  input logic         ovf_o,
  input logic         neg_o,
  input logic [W-1:0] cmp_o
);
  always_comb begin
    if (!sub_i) a_r1_add: assert (sum_o == a_i + b_i);
    if (sub_i)  a_r2_sub: assert (sum_o == a_i - b_i);
    a_r3_zero: assert (zero_o == (sum_o == '0));
    a_r4_neg: assert (neg_o == sum_o[W-1]);
    if (a_i[W-1] != (b_i[W-1] ^ sub_i)) a_r5_no_overflow: assert (!ovf_o);
    a_r6_upper_zero: assert (cmp_o[W-1:1] == '0);
    if (cmp_sel_i == 2'b01) a_r7_eq: assert (cmp_o[0] == zero_o);
    if (cmp_sel_i == 2'b10) a_r8_lt: assert (cmp_o[0] == (neg_o ^ ovf_o));
    if (cmp_sel_i == 2'b11) a_r9_le: assert (cmp_o[0] == (zero_o | (neg_o ^ ovf_o)));
    if (cmp_sel_i == 2'b00) a_r10_none: assert (cmp_o == '0);
    if (sub_i) a_r11_unreachable: assert (!(zero_o && (neg_o || ovf_o)));
  end
endmodule

bind addsub_cmp addsub_cmp_chk #(.W(W)) u_chk (.*);

// File: tb/addsub_cmp_tb.sv
`timescale 1ns/1ps
module addsub_cmp_tb;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] sum;
    logic         z, v, n;
    logic [W-1:0] cmp;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b;
  logic         sub;
  logic [1:0]   sel;
  logic [W-1:0] sum, cmp;
  logic         z, v, n;

  addsub_cmp #(.W(W)) u_dut (
    .a_i(a), .b_i(b), .sub_i(sub), .cmp_sel_i(sel),
    .sum_o(sum), .zero_o(z), .ovf_o(v), .neg_o(n), .cmp_o(cmp)
  );

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic drive(input logic [W-1:0] ta, input logic [W-1:0] tb,
                       input logic ts, input logic [1:0] tsel, input string tag);
    exp_t e;
    longint sa, sb, full;
    logic bit0;
    @(posedge clk);
    #1;
    a = ta; b = tb; sub = ts; sel = tsel;
    sa = longint'($signed(ta));
    sb = longint'($signed(tb));
    full = ts ? sa - sb : sa + sb;
    e.sum = ts ? ta - tb : ta + tb;
    e.z = (e.sum == '0);
    e.n = e.sum[W-1];
    e.v = (full > 64'sd2147483647) || (full < -64'sd2147483648);
    if (ts) begin
      case (tsel)
        2'b01: bit0 = (ta == tb);
        2'b10: bit0 = ($signed(ta) < $signed(tb));
        2'b11: bit0 = ($signed(ta) <= $signed(tb));
        default: bit0 = 1'b0;
      endcase
    end else begin
      case (tsel)
        2'b01: bit0 = e.z;
        2'b10: bit0 = e.n ^ e.v;
        2'b11: bit0 = e.z | (e.n ^ e.v);
        default: bit0 = 1'b0;
      endcase
    end
    e.cmp = {{(W-1){1'b0}}, bit0};
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (sum !== e.sum || z !== e.z || v !== e.v || n !== e.n || cmp !== e.cmp) begin
        fails++;
        $display("FAIL %s: a=%h b=%h sub=%b sel=%b got sum=%h z%b v%b n%b cmp=%h exp sum=%h z%b v%b n%b cmp=%h",
                 e.tag, a, b, sub, sel, sum, z, v, n, cmp, e.sum, e.z, e.v, e.n, e.cmp);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lf;
    a = '0; b = '0; sub = 1'b0; sel = 2'b00;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // idle state, all-zero inputs: R3 zero flag, R10 no compare
    drive('0, '0, 1'b0, 2'b00, "R3 R10 idle");
    // R1 adder bit patterns
    drive(32'h55555555, 32'h00000000, 1'b0, 2'b00, "R1");
    drive(32'h00000000, 32'h55555555, 1'b0, 2'b00, "R1");
    drive(32'h55555555, 32'h55555555, 1'b0, 2'b00, "R1");
    drive(32'hAAAAAAAA, 32'h00000000, 1'b0, 2'b00, "R1");
    drive(32'h00000000, 32'hAAAAAAAA, 1'b0, 2'b00, "R1");
    drive(32'hAAAAAAAA, 32'hAAAAAAAA, 1'b0, 2'b00, "R1 R5");
    drive(32'hFFFFFFFF, 32'h00000001, 1'b0, 2'b00, "R1 R3");
    drive(32'h00000001, 32'hFFFFFFFF, 1'b0, 2'b00, "R1 R3");
    drive(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 2'b00, "R1 R4");
    drive(32'h7FFFFFFF, 32'h00000001, 1'b0, 2'b10, "R5 R8 add overflow");
    drive(32'h80000000, 32'h80000000, 1'b0, 2'b01, "R5 R7 add overflow to zero");
    // R2 / flag combinations with every compare select
    for (int s = 0; s < 4; s++) begin
      drive(32'h12345678, 32'h12345678, 1'b1, 2'(s), "R2 R3 R7 R11 equal");
      drive(32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1, 2'(s), "R2 R5 R8 V1N1");
      drive(32'h80000000, 32'h00000001, 1'b1, 2'(s), "R2 R5 R9 V1N0");
      drive(32'h00000005, 32'hDEADBEEF, 1'b1, 2'(s), "R2 R9 noflags");
      drive(32'hDEADBEEF, 32'h00000005, 1'b1, 2'(s), "R2 R4 R8 neg");
      drive(32'h00000003, 32'h00000007, 1'b1, 2'(s), "R6 R10 small");
    end
    lf = 32'hACE1_2468;
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] ra, rb;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ra = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      rb = (k % 7 == 0) ? ra : lf;
      drive(ra, rb, lf[3], lf[5:4], "R1 R2 R5 R9 random");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule